// File: doc/BRIEF.md
# Multi-Key-Length AES Encryption Engine

This block encrypts one 128-bit block per operation with the AES cipher, using a key of 128, 192 or 256 bits. The key length is chosen for each operation by a two-bit mode input that is sampled together with the start strobe. The key bus is 256 bits wide. Shorter keys sit in its upper bits, and the bits below the selected length are not used.

The engine is iterative. At the accepting edge it loads the state with the plaintext XOR the first round key. It then performs one full round per clock: byte substitution through a lookup table, row rotation, column mixing and key addition, with column mixing left out of the final round. The round keys are expanded on the fly. A single eight-word sliding window yields four new 32-bit words per cycle for every key length. A single controller counts the rounds for the length that was sampled.

Top module: `aes_mkc_core`

## Requirements
- R1: While reset is held and after it is released, `ctext` reads all zeros and `done` is low. A start given on the first cycle after release is accepted.
- R2: Mode 2'b00 selects a 128-bit key taken from `key[255:128]` and runs 10 rounds. The state byte order is column-major: `ptext[127:120]` is row 0 of column 0, and the next byte down is row 1 of column 0. The ciphertext uses the same byte order.
- R3: Mode 2'b01 selects a 192-bit key taken from `key[255:64]` and runs 12 rounds.
- R4: Mode 2'b10 selects the full 256-bit key and runs 14 rounds.
- R5: `done` is high for exactly one cycle, Nr rising edges after the edge that accepted start, where Nr is the round count of the mode. `ctext` holds the result in that cycle.
- R6: Once an operation has finished, `ctext` keeps its value until the next start is accepted.
- R7: A start that arrives while an operation runs is ignored. The running operation keeps its key, mode, timing and result, and no extra `done` is produced.
- R8: Mode 2'b11 behaves exactly like mode 2'b00.
- R9: Key bits below the selected key length have no effect on the result.
- R10: A start in the same cycle that `done` is high is accepted. Consecutive operations may use different modes and keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 2 | Key length: 00 = 128, 01 = 192, 10 = 256, 11 = 128 |
| key | input | 256 | Cipher key, left-aligned |
| ptext | input | 128 | Plaintext block |
| ctext | output | 128 | Ciphertext / state register |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the 192-bit schedule. There, the words of a round key come partly from the sliding window and partly from the current generation step, and the schedule events fall at three different phases of the step. The known-answer vectors for each length cover every such phase, because a misplaced word in any round corrupts the result. Two further situations depend on timing: a start arriving during a run, and a start falling in the completion cycle. The stimulus pulses start a few cycles into a 192-bit run with different inputs. It also chains operations directly off the `done` cycle, changing the mode each time.

// File: rtl/aes_mkc_pkg.sv
`timescale 1ns/1ps
package aes_mkc_pkg;

  localparam int BLK_W    = 128;
  localparam int WORD_W   = 32;
  localparam int KEY_W    = 256;
  localparam int MAX_NK   = KEY_W / WORD_W;
  localparam int STEP_W   = BLK_W / WORD_W;
  localparam int MAX_NR   = MAX_NK + 6;
  localparam int RND_W    = $clog2(MAX_NR + 1);
  localparam int WIN_IW   = $clog2(MAX_NK);

  typedef enum logic [1:0] {KL_128 = 2'd0, KL_192 = 2'd1, KL_256 = 2'd2} klen_e;

  typedef logic [255:0][7:0] sbox_tab_t;

  function automatic klen_e decode_klen(input logic [1:0] m);
    case (m)
      2'd1:    return KL_192;
      2'd2:    return KL_256;
      default: return KL_128;
    endcase
  endfunction

  function automatic logic [3:0] nk_of(input klen_e k);
    case (k)
      KL_192:  return 4'd6;
      KL_256:  return 4'd8;
      default: return 4'd4;
    endcase
  endfunction

  function automatic logic [3:0] nr_of(input klen_e k);
    return nk_of(k) + 4'd6;
  endfunction

  function automatic logic [7:0] xtime(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    logic [15:0] d;
    d = {v, v} << n;
    return d[15:8];
  endfunction

  // Walks the multiplicative group with generator 3 and its inverse in
  // lock-step, so each visited element is paired with its inverse.
  function automatic sbox_tab_t build_sbox();
    sbox_tab_t t;
    logic [7:0] p, q, x;
    t = '0;
    p = 8'h01;
    q = 8'h01;
    t[0] = 8'h63;
    for (int it = 0; it < 255; it++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1B : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4);
      t[p] = x ^ 8'h63;
    end
    return t;
  endfunction

  localparam sbox_tab_t SBOX_TAB = build_sbox();

  function automatic logic [WORD_W-1:0] sub_word(input logic [WORD_W-1:0] w);
    return {SBOX_TAB[w[31:24]], SBOX_TAB[w[23:16]],
            SBOX_TAB[w[15:8]],  SBOX_TAB[w[7:0]]};
  endfunction

endpackage

// File: rtl/aes_mkc_sbox.sv
`timescale 1ns/1ps
module aes_mkc_sbox
  import aes_mkc_pkg::*;
(
  input  logic [7:0] din,
  output logic [7:0] dout
);
  assign dout = SBOX_TAB[din];
endmodule

// File: rtl/aes_mkc_round.sv
`timescale 1ns/1ps
module aes_mkc_round
  import aes_mkc_pkg::*;
#(
  parameter int W = BLK_W
) (
  input  logic [W-1:0] st_i,
  input  logic [W-1:0] rk_i,
  input  logic         last_i,
  output logic [W-1:0] st_o
);
  localparam int NBYTES = W / 8;
  localparam int NCOL   = NBYTES / 4;

  logic [NBYTES-1:0][7:0] sb_b;
  logic [NBYTES-1:0][7:0] sr_b;
  logic [NBYTES-1:0][7:0] mc_b;

  // byte b lives at st[W-1-8b -: 8]; b = row + 4*column
  for (genvar b = 0; b < NBYTES; b++) begin : g_sub
    aes_mkc_sbox i_sbox (
      .din  (st_i[W-1-8*b -: 8]),
      .dout (sb_b[b])
    );
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      assign sr_b[r + 4*c] = sb_b[r + 4*((c + r) % NCOL)];
    end

    assign mc_b[4*c]   = xtime(sr_b[4*c]) ^ xtime(sr_b[4*c+1]) ^ sr_b[4*c+1]
                       ^ sr_b[4*c+2] ^ sr_b[4*c+3];
    assign mc_b[4*c+1] = sr_b[4*c] ^ xtime(sr_b[4*c+1]) ^ xtime(sr_b[4*c+2])
                       ^ sr_b[4*c+2] ^ sr_b[4*c+3];
    assign mc_b[4*c+2] = sr_b[4*c] ^ sr_b[4*c+1] ^ xtime(sr_b[4*c+2])
                       ^ xtime(sr_b[4*c+3]) ^ sr_b[4*c+3];
    assign mc_b[4*c+3] = xtime(sr_b[4*c]) ^ sr_b[4*c] ^ sr_b[4*c+1]
                       ^ sr_b[4*c+2] ^ xtime(sr_b[4*c+3]);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_out
    assign st_o[W-1-8*b -: 8] = (last_i ? sr_b[b] : mc_b[b]) ^ rk_i[W-1-8*b -: 8];
  end
endmodule

// File: rtl/aes_mkc_keysched.sv
`timescale 1ns/1ps
module aes_mkc_keysched
  import aes_mkc_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_i,
  input  logic                   step_i,
  input  klen_e                  load_len_i,
  input  klen_e                  run_len_i,
  input  logic [KEY_W-1:0]       key_i,
  output logic [BLK_W-1:0]       rk_o
);
  localparam int CAT_N = MAX_NK + STEP_W;

  logic [MAX_NK-1:0][WORD_W-1:0] win_q, win_d;   // win[k] = w[i-1-k]
  logic [WIN_IW-1:0]             pos_q, pos_d;   // i mod Nk
  logic [7:0]                    rcon_q, rcon_d;
  logic [MAX_NK-1:0][WORD_W-1:0] kw;             // kw[MAX_NK-1] = w0
  logic [STEP_W-1:0][WORD_W-1:0] nw;             // nw[j] = w[i+j]
  logic [STEP_W-1:0][WORD_W-1:0] rk_w;           // rk_w[STEP_W-1] = first word
  logic                          ev;
  logic [3:0]                    nk_run, nk_ld;

  assign kw     = key_i;
  assign nk_run = nk_of(run_len_i);
  assign nk_ld  = nk_of(load_len_i);

  // four new schedule words from the window
  always_comb begin
    logic [WORD_W-1:0] t;
    logic [3:0]        s;
    ev = 1'b0;
    t  = win_q[0];
    nw = '0;
    for (int j = 0; j < STEP_W; j++) begin
      s = 4'(pos_q) + 4'(j);
      if (s >= nk_run) s = s - nk_run;
      if (s == 4'd0) begin
        t  = sub_word({t[23:0], t[31:24]}) ^ {rcon_q, 24'h0};
        ev = 1'b1;
      end else if (run_len_i == KL_256 && s == 4'd4) begin
        t = sub_word(t);
      end
      nw[2'(j)] = win_q[WIN_IW'(int'(nk_run) - 1 - j)] ^ t;
      t = nw[2'(j)];
    end
  end

  // round key: four words starting at 12 - Nk in {window oldest..newest, new}
  always_comb begin
    int m;
    rk_w = '0;
    for (int j = 0; j < STEP_W; j++) begin
      m = CAT_N - int'(nk_run) + j;
      if (m < MAX_NK) rk_w[2'(STEP_W-1-j)] = win_q[WIN_IW'(MAX_NK - 1 - m)];
      else            rk_w[2'(STEP_W-1-j)] = nw[2'(m - MAX_NK)];
    end
  end
  assign rk_o = rk_w;

  // next state
  always_comb begin
    logic [3:0] p;
    win_d  = win_q;
    pos_d  = pos_q;
    rcon_d = rcon_q;
    p      = 4'(pos_q) + 4'(STEP_W);
    if (p >= nk_run) p = p - nk_run;
    if (load_i) begin
      for (int k = 0; k < MAX_NK; k++) begin
        if (k < int'(nk_ld)) win_d[WIN_IW'(k)] = kw[WIN_IW'(MAX_NK - int'(nk_ld) + k)];
        else                 win_d[WIN_IW'(k)] = '0;
      end
      pos_d  = '0;
      rcon_d = 8'h01;
    end else if (step_i) begin
      for (int k = 0; k < STEP_W; k++) begin
        win_d[WIN_IW'(k)]          = nw[2'(STEP_W-1-k)];
        win_d[WIN_IW'(k + STEP_W)] = win_q[WIN_IW'(k)];
      end
      pos_d  = WIN_IW'(p);
      rcon_d = ev ? xtime(rcon_q) : rcon_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      pos_q  <= '0;
      rcon_q <= 8'h01;
    end else if (load_i || step_i) begin
      win_q  <= win_d;
      pos_q  <= pos_d;
      rcon_q <= rcon_d;
    end
  end

  assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (4'(pos_q) < nk_run));

  assert_rcon_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (rcon_q != 8'h00));
endmodule

// File: rtl/aes_mkc_ctrl.sv
`timescale 1ns/1ps
module aes_mkc_ctrl
  import aes_mkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] mode_i,
  output logic       load_o,
  output logic       step_o,
  output logic       last_o,
  output logic       done_o,
  output klen_e      len_o
);
  logic             busy_q, busy_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  klen_e            len_q, len_d;
  logic             done_q, done_d;
  logic             accept;

  assign accept = start_i && !busy_q;
  assign load_o = accept;
  assign step_o = busy_q;
  assign last_o = busy_q && (4'(rnd_q) == nr_of(len_q));
  assign done_o = done_q;
  assign len_o  = len_q;

  always_comb begin
    busy_d = busy_q;
    rnd_d  = rnd_q;
    len_d  = len_q;
    done_d = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      rnd_d  = RND_W'(1);
      len_d  = decode_klen(mode_i);
    end else if (busy_q) begin
      if (last_o) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        rnd_d = rnd_q + RND_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rnd_q  <= '0;
      len_q  <= KL_128;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      rnd_q  <= rnd_d;
      len_q  <= len_d;
      done_q <= done_d;
    end
  end

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  assert_done_follows_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (done_q && !busy_q));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> (len_q == $past(len_q)));

  assert_round_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_o) |=> (busy_q && rnd_q == RND_W'($past(rnd_q) + 1'b1)));

  assert_round_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (4'(rnd_q) <= nr_of(len_q) && rnd_q != '0));
endmodule

// File: rtl/aes_mkc_core.sv
`timescale 1ns/1ps
module aes_mkc_core
  import aes_mkc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [1:0]         mode,
  input  logic [KEY_W-1:0]   key,
  input  logic [BLK_W-1:0]   ptext,
  output logic [BLK_W-1:0]   ctext,
  output logic               done
);
  logic             load, step, last;
  klen_e            run_len;
  logic [BLK_W-1:0] rk, rnd_out;
  logic [BLK_W-1:0] st_q, st_d;

  aes_mkc_ctrl i_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .mode_i  (mode),
    .load_o  (load),
    .step_o  (step),
    .last_o  (last),
    .done_o  (done),
    .len_o   (run_len)
  );

  aes_mkc_keysched i_ks (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load),
    .step_i     (step),
    .load_len_i (decode_klen(mode)),
    .run_len_i  (run_len),
    .key_i      (key),
    .rk_o       (rk)
  );

  aes_mkc_round #(.W(BLK_W)) i_round (
    .st_i   (st_q),
    .rk_i   (rk),
    .last_i (last),
    .st_o   (rnd_out)
  );

  always_comb begin
    st_d = st_q;
    if (load)      st_d = ptext ^ key[KEY_W-1 -: BLK_W];
    else if (step) st_d = rnd_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             st_q <= '0;
    else if (load || step)  st_q <= st_d;
  end

  assign ctext = st_q;

  assert_ct_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !start) |=> $stable(ctext));
endmodule

// File: tb/test_aes_mkc_core.sv
`timescale 1ns/1ps
module test_aes_mkc_core;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   mode;
  logic [255:0] key;
  logic [127:0] ptext;
  logic [127:0] ctext;
  logic         done;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit finished = 1'b0;

  logic [127:0] q_exp [$];
  int           q_due [$];
  string        q_tag [$];
  logic [127:0] last_exp;

  localparam logic [127:0] PT_A  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [255:0] K_256 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] CT128 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] CT192 = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
  localparam logic [127:0] CT256 = 128'h8ea2b7ca516745bfeafc49904b496089;
  localparam logic [127:0] PT_B  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [255:0] K_B   = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [127:0] CT_B  = 128'h3925841d02dc09fbdc118597196a0b32;

  aes_mkc_core i_aes_mkc_core (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .mode  (mode),
    .key   (key),
    .ptext (ptext),
    .ctext (ctext),
    .done  (done)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; start is sampled at the next rising edge.
  task automatic issue(input logic [1:0] m, input logic [255:0] k, input logic [127:0] p,
                       input logic [127:0] exp, input int nr, input string tag);
    start = 1'b1;
    mode  = m;
    key   = k;
    ptext = p;
    q_exp.push_back(exp);
    q_due.push_back(cyc + 1 + nr);
    q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_drain();
    while (q_exp.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_done_cycle();
    do @(negedge clk); while (!done);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n === 1'b1 && done === 1'b1) begin
      if (q_exp.size() == 0) begin
        check(1'b0, "R7 unexpected done", ctext, 128'h0);
      end else begin
        logic [127:0] e;
        int d;
        string t;
        e = q_exp.pop_front();
        d = q_due.pop_front();
        t = q_tag.pop_front();
        last_exp = e;
        check(ctext === e, t, ctext, e);
        check(cyc == d, {"R5 latency ", t}, 128'(cyc), 128'(d));
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "R5 watchdog expired", 128'(cyc), 128'h0);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    mode  = 2'b00;
    key   = '0;
    ptext = '0;
    repeat (3) @(negedge clk);
    check(ctext === 128'h0, "R1 ctext in reset", ctext, 128'h0);
    check(done === 1'b0, "R1 done in reset", 128'(done), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctext === 128'h0 && done === 1'b0, "R1 after release", ctext, 128'h0);

    issue(2'b00, K_256, PT_A, CT128, 10, "R2 128-bit known answer");
    wait_drain();
    repeat (5) @(negedge clk);
    check(ctext === last_exp, "R6 ctext held", ctext, last_exp);

    issue(2'b01, K_256, PT_A, CT192, 12, "R3 192-bit known answer");
    wait_drain();
    issue(2'b10, K_256, PT_A, CT256, 14, "R4 256-bit known answer");
    wait_drain();

    issue(2'b00, {K_256[255:128], {4{32'hdeadbeef}}}, PT_A, CT128, 10, "R9 128 low bits junk");
    wait_drain();
    issue(2'b01, {K_256[255:64], 64'hcafef00d5a5aa5a5}, PT_A, CT192, 12, "R9 192 low bits junk");
    wait_drain();
    issue(2'b11, K_256, PT_A, CT128, 10, "R8 mode 11 as 128");
    wait_drain();

    // back-to-back, mode changes, start in done cycle
    issue(2'b10, K_256, PT_A, CT256, 14, "R10 chain first 256");
    wait_done_cycle();
    issue(2'b00, K_B, PT_B, CT_B, 10, "R10 chain second 128");
    wait_done_cycle();
    issue(2'b01, K_256, PT_A, CT192, 12, "R10 chain third 192");
    wait_drain();

    // start while busy must be ignored
    issue(2'b01, K_256, PT_A, CT192, 12, "R7 run with mid-run start");
    repeat (2) @(negedge clk);
    start = 1'b1;
    mode  = 2'b00;
    key   = K_B;
    ptext = PT_B;
    @(negedge clk);
    start = 1'b0;
    wait_drain();
    repeat (20) @(negedge clk);
    check(ctext === CT192, "R7 result unchanged after ignored start", ctext, CT192);
    check(q_exp.size() == 0, "R7 scoreboard empty", 128'(q_exp.size()), 128'h0);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule